// File: doc/BRIEF.md
# TCP Flow Routing Decision Engine

This block receives one parsed IP header at a time and decides where the packet goes. There are three outcomes: the outbound IP path only, both the client application and the outbound path, or a drop. For every flow it keeps a one-entry record in a synchronous table. The record holds the next sequence number it expects and an active flag. The table is addressed directly by a hashed flow index that an upstream stage supplies.

The routing rule enforces in-order delivery to the client without any reassembly. A TCP segment that lands exactly on the expected sequence number goes to both destinations, and the record moves forward by the payload length. A segment that falls behind the expected value only passes through. A segment that runs ahead of it is dropped. A SYN re-arms the record. Other rules sit ahead of the sequence comparison: a packet that is not TCP always passes through, and a bad checksum always drops the packet.

A header is accepted when `hdr_valid` and `hdr_ready` are both high at a clock edge. The decision appears two edges later. The table write for that header lands before the next header can be read. After reset the block clears every record before it accepts any traffic. The index width is a parameter: the default is 8 bits, and 18 bits gives 256K flows.

Top module: `tcpr_engine`

## Requirements
- R1: An accepted header produces exactly one `route_valid` pulse, one cycle wide, after the second rising edge following acceptance. Each pulse comes with `route_flow` equal to the header's flow index. The `route` encoding is 2'b00 drop, 2'b01 outbound only, 2'b11 client and outbound.
- R2: A header with `hdr_is_tcp`=0 is routed 2'b01 whatever the other fields hold, and its flow record is left unchanged.
- R3: A TCP header with `hdr_csum_ok`=0 is routed 2'b00 even when SYN is set, and its flow record is left unchanged.
- R4: A TCP SYN with a good checksum is routed 2'b01. It sets its record to active, with the expected sequence equal to seq+1 modulo 2^32, even if the record was already active.
- R5: A good non-SYN TCP header on an inactive record is routed 2'b11. It activates the record with the expected sequence equal to seq+len.
- R6: On an active record, a sequence number below the expected value is routed 2'b01, and the record is unchanged.
- R7: On an active record, a sequence number above the expected value is routed 2'b00, and the record is unchanged.
- R8: On an active record, a sequence number equal to the expected value is routed 2'b11, and the expected value becomes seq+len modulo 2^32. A length of zero leaves it unchanged.
- R9: The comparison is plain unsigned 32-bit, with no window wraparound: 0xFFFFFFF0 is above 16, and 5 is below 0xFFFFFFF1.
- R10: `hdr_ready` is low for the one cycle after an acceptance. A header held during that cycle is not taken then, and when it is taken it sees the update made by the previous header.
- R11: After reset is released, `hdr_ready` stays low for exactly 2^IDX_W+2 rising edges while every record is cleared to inactive. No `route_valid` appears in that time, and a `hdr_valid` presented then is ignored.
- R12: Records are selected only by `hdr_flow`. Traffic on one index never changes another index's record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hdr_valid | input | 1 | Header fields are present |
| hdr_ready | output | 1 | Block can take a header this cycle |
| hdr_is_tcp | input | 1 | Protocol is TCP |
| hdr_csum_ok | input | 1 | Checksum check passed |
| hdr_syn | input | 1 | SYN flag |
| hdr_seq | input | 32 | Sequence number |
| hdr_len | input | LEN_W | Payload length in bytes |
| hdr_flow | input | IDX_W | Hashed flow index |
| route_valid | output | 1 | Decision strobe |
| route | output | 2 | Routing outcome |
| route_flow | output | IDX_W | Flow index of the decision |

## Verification
The bench focuses on rule priority. A bad checksum on a SYN must drop the packet, and a SYN on a non-TCP packet must not touch the record. A design with the priority wrong would forward those packets or re-arm the flow. The bench also drives sequence numbers and lengths that cross 2^32, and checks that a design handling signed or windowed comparisons would misroute them. It reuses records after a drop, after a pass-through and after a re-SYN, so a design that updated the record on those outcomes would misroute the following in-order segment. Back-to-back headers on the same flow and a second reset show whether the write lands before the next read, and whether the clearing sweep really empties the table.

// File: rtl/tcpr_pkg.sv
package tcpr_pkg;
  localparam int SEQ_W = 32;

  typedef enum logic [1:0] {
    RT_DROP = 2'b00,
    RT_OUT  = 2'b01,
    RT_BOTH = 2'b11
  } route_e;

  typedef struct packed {
    logic             active;
    logic [SEQ_W-1:0] nxt_seq;
  } flow_ent_t;
endpackage

// File: rtl/tcpr_rst_sync.sv
module tcpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/tcpr_flow_table.sv
module tcpr_flow_table
  import tcpr_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output flow_ent_t        rd_ent,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  flow_ent_t        wr_ent
);
  localparam int DEPTH = 1 << IDX_W;

  flow_ent_t mem_q [DEPTH];
  flow_ent_t rd_q;

  // Storage array: no reset, cleared by the sweep in the top level.
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem_q[rd_idx];
  end

  assign rd_ent = rd_q;
endmodule

// File: rtl/tcpr_decide.sv
module tcpr_decide
  import tcpr_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             is_tcp,
  input  logic             csum_ok,
  input  logic             syn,
  input  logic [SEQ_W-1:0] seq,
  input  logic [LEN_W-1:0] len,
  input  flow_ent_t        cur,
  output route_e           route,
  output logic             upd,
  output flow_ent_t        nxt
);
  logic [SEQ_W-1:0] seq_end;
  logic             seq_lo, seq_hi;

  assign seq_end = seq + SEQ_W'(len);
  assign seq_lo  = seq < cur.nxt_seq;
  assign seq_hi  = seq > cur.nxt_seq;

  always_comb begin
    route       = RT_OUT;
    upd         = 1'b0;
    nxt.active  = 1'b1;
    nxt.nxt_seq = seq_end;
    if (!is_tcp) begin
      route = RT_OUT;
    end else if (!csum_ok) begin
      route = RT_DROP;
    end else if (syn) begin
      route       = RT_OUT;
      upd         = 1'b1;
      nxt.nxt_seq = seq + SEQ_W'(1);
    end else if (!cur.active) begin
      route = RT_BOTH;
      upd   = 1'b1;
    end else if (seq_lo) begin
      route = RT_OUT;
    end else if (seq_hi) begin
      route = RT_DROP;
    end else begin
      route = RT_BOTH;
      upd   = 1'b1;
    end
  end
endmodule

// File: rtl/tcpr_engine.sv
module tcpr_engine
  import tcpr_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_valid,
  output logic             hdr_ready,
  input  logic             hdr_is_tcp,
  input  logic             hdr_csum_ok,
  input  logic             hdr_syn,
  input  logic [31:0]      hdr_seq,
  input  logic [LEN_W-1:0] hdr_len,
  input  logic [IDX_W-1:0] hdr_flow,
  output logic             route_valid,
  output logic [1:0]       route,
  output logic [IDX_W-1:0] route_flow
);
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  logic rst_i_n;
  tcpr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  // Control state
  logic             init_q, init_d;
  logic [IDX_W-1:0] icnt_q, icnt_d;
  logic             a_vld_q, a_vld_d;
  logic             o_vld_q, o_vld_d;
  logic             accept;

  // Stage A header fields
  logic             a_tcp_q, a_ok_q, a_syn_q;
  logic [SEQ_W-1:0] a_seq_q;
  logic [LEN_W-1:0] a_len_q;
  logic [IDX_W-1:0] a_flow_q;

  // Output fields
  route_e           o_route_q;
  logic [IDX_W-1:0] o_flow_q;

  // Table and decision wiring
  flow_ent_t        rd_ent, new_ent, wr_ent;
  logic             upd, wr_en;
  logic [IDX_W-1:0] wr_idx;
  route_e           dec_route;

  assign hdr_ready = ~init_q & ~a_vld_q;
  assign accept    = hdr_valid & hdr_ready;

  always_comb begin
    init_d  = init_q & (icnt_q != LAST_IDX);
    icnt_d  = init_q ? icnt_q + IDX_W'(1) : icnt_q;
    a_vld_d = accept;
    o_vld_d = a_vld_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      init_q  <= 1'b1;
      icnt_q  <= '0;
      a_vld_q <= 1'b0;
      o_vld_q <= 1'b0;
    end else begin
      init_q  <= init_d;
      icnt_q  <= icnt_d;
      a_vld_q <= a_vld_d;
      o_vld_q <= o_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      a_tcp_q  <= 1'b0;
      a_ok_q   <= 1'b0;
      a_syn_q  <= 1'b0;
      a_seq_q  <= '0;
      a_len_q  <= '0;
      a_flow_q <= '0;
    end else if (accept) begin
      a_tcp_q  <= hdr_is_tcp;
      a_ok_q   <= hdr_csum_ok;
      a_syn_q  <= hdr_syn;
      a_seq_q  <= hdr_seq;
      a_len_q  <= hdr_len;
      a_flow_q <= hdr_flow;
    end
  end

  tcpr_flow_table #(.IDX_W(IDX_W)) u_tab (
    .clk    (clk),
    .rd_en  (accept),
    .rd_idx (hdr_flow),
    .rd_ent (rd_ent),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_ent (wr_ent)
  );

  tcpr_decide #(.LEN_W(LEN_W)) u_dec (
    .is_tcp  (a_tcp_q),
    .csum_ok (a_ok_q),
    .syn     (a_syn_q),
    .seq     (a_seq_q),
    .len     (a_len_q),
    .cur     (rd_ent),
    .route   (dec_route),
    .upd     (upd),
    .nxt     (new_ent)
  );

  always_comb begin
    if (init_q) begin
      wr_en  = 1'b1;
      wr_idx = icnt_q;
      wr_ent = '0;
    end else begin
      wr_en  = a_vld_q & upd;
      wr_idx = a_flow_q;
      wr_ent = new_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      o_route_q <= RT_DROP;
      o_flow_q  <= '0;
    end else if (a_vld_q) begin
      o_route_q <= dec_route;
      o_flow_q  <= a_flow_q;
    end
  end

  assign route_valid = o_vld_q;
  assign route       = o_route_q;
  assign route_flow  = o_flow_q;
endmodule

// File: rtl/tcpr_engine_chk.sv
module tcpr_engine_chk #(
  parameter int IDX_W = 8,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic             hdr_ready,
  input logic             hdr_is_tcp,
  input logic             hdr_csum_ok,
  input logic             hdr_syn,
  input logic [IDX_W-1:0] hdr_flow,
  input logic             route_valid,
  input logic [1:0]       route,
  input logic [IDX_W-1:0] route_flow
);
  logic acc;
  assign acc = hdr_valid & hdr_ready;

  assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> ##2 route_valid);
  assert_strobe_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> $past(acc, 2));
  assert_flow_echo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> ##2 (route_flow == $past(hdr_flow, 2)));
  assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> (route != 2'b10));
  assert_non_tcp_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hdr_is_tcp) |-> ##2 (route == 2'b01));
  assert_bad_csum_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hdr_is_tcp && !hdr_csum_ok) |-> ##2 (route == 2'b00));
  assert_syn_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hdr_is_tcp && hdr_csum_ok && hdr_syn) |-> ##2 (route == 2'b01));
  assert_busy_after_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !hdr_ready);
endmodule

bind tcpr_engine tcpr_engine_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hdr_valid   (hdr_valid),
  .hdr_ready   (hdr_ready),
  .hdr_is_tcp  (hdr_is_tcp),
  .hdr_csum_ok (hdr_csum_ok),
  .hdr_syn     (hdr_syn),
  .hdr_flow    (hdr_flow),
  .route_valid (route_valid),
  .route       (route),
  .route_flow  (route_flow)
);

// File: tb/sim_tcpr_engine.sv
module sim_tcpr_engine;
  localparam int IDX_W = 8;
  localparam int LEN_W = 16;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [1:0] DR = 2'b00, OU = 2'b01, BO = 2'b11;

  typedef struct packed {
    logic        tcp;
    logic        ok;
    logic        syn;
    logic [31:0] seq;
    logic [15:0] len;
    logic [7:0]  flow;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 32'd100,        16'd0,  8'd1,   OU}, // R2 non-TCP
    '{1'b1, 1'b0, 1'b1, 32'd100,        16'd0,  8'd1,   DR}, // R3 bad csum beats SYN
    '{1'b1, 1'b1, 1'b0, 32'd500,        16'd10, 8'd1,   BO}, // R5 inactive -> 510
    '{1'b1, 1'b1, 1'b0, 32'd510,        16'd20, 8'd1,   BO}, // R8 -> 530
    '{1'b1, 1'b1, 1'b0, 32'd520,        16'd4,  8'd1,   OU}, // R6 behind
    '{1'b1, 1'b1, 1'b0, 32'd600,        16'd4,  8'd1,   DR}, // R7 ahead
    '{1'b1, 1'b1, 1'b0, 32'd530,        16'd0,  8'd1,   BO}, // R6/R7 no update, len 0
    '{1'b1, 1'b1, 1'b0, 32'd530,        16'd5,  8'd1,   BO}, // R8 -> 535
    '{1'b1, 1'b1, 1'b1, 32'd1000,       16'd9,  8'd2,   OU}, // R4 SYN -> 1001
    '{1'b1, 1'b1, 1'b0, 32'd1001,       16'd4,  8'd2,   BO}, // R4 seq+1
    '{1'b1, 1'b1, 1'b0, 32'd535,        16'd1,  8'd1,   BO}, // R12 flow 1 intact
    '{1'b1, 1'b1, 1'b1, 32'hFFFFFFFF,   16'd0,  8'd3,   OU}, // R4 SYN -> 0
    '{1'b1, 1'b1, 1'b0, 32'd0,          16'd16, 8'd3,   BO}, // R8 wrap -> 16
    '{1'b1, 1'b1, 1'b0, 32'hFFFFFFF0,   16'd1,  8'd3,   DR}, // R9 unsigned above
    '{1'b1, 1'b1, 1'b1, 32'hFFFFFFF0,   16'd0,  8'd4,   OU}, // R4 -> FFFFFFF1
    '{1'b1, 1'b1, 1'b0, 32'd5,          16'd1,  8'd4,   OU}, // R9 unsigned below
    '{1'b1, 1'b1, 1'b0, 32'hFFFFFFF1,   16'd15, 8'd4,   BO}, // R8 mod -> 0
    '{1'b1, 1'b1, 1'b0, 32'd0,          16'd1,  8'd4,   BO}, // R8 -> 1
    '{1'b1, 1'b0, 1'b0, 32'd1,          16'd7,  8'd4,   DR}, // R3 drop
    '{1'b1, 1'b1, 1'b0, 32'd1,          16'd0,  8'd4,   BO}, // R3 no update
    '{1'b0, 1'b1, 1'b1, 32'd0,          16'd3,  8'd4,   OU}, // R2 non-TCP SYN
    '{1'b1, 1'b1, 1'b0, 32'd1,          16'd0,  8'd4,   BO}, // R2 no update
    '{1'b1, 1'b1, 1'b1, 32'd50,         16'd0,  8'd1,   OU}, // R4 re-SYN -> 51
    '{1'b1, 1'b1, 1'b0, 32'd51,         16'd0,  8'd1,   BO}, // R4 re-armed
    '{1'b1, 1'b1, 1'b0, 32'd7,          16'd3,  8'd255, BO}  // R12 top index
  };

  logic             clk, rst_n;
  logic             hdr_valid, hdr_ready, hdr_is_tcp, hdr_csum_ok, hdr_syn;
  logic [31:0]      hdr_seq;
  logic [LEN_W-1:0] hdr_len;
  logic [IDX_W-1:0] hdr_flow;
  logic             route_valid;
  logic [1:0]       route;
  logic [IDX_W-1:0] route_flow;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  tcpr_engine #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_is_tcp(hdr_is_tcp), .hdr_csum_ok(hdr_csum_ok), .hdr_syn(hdr_syn),
    .hdr_seq(hdr_seq), .hdr_len(hdr_len), .hdr_flow(hdr_flow),
    .route_valid(route_valid), .route(route), .route_flow(route_flow)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    hdr_is_tcp  = v.tcp;
    hdr_csum_ok = v.ok;
    hdr_syn     = v.syn;
    hdr_seq     = v.seq;
    hdr_len     = v.len;
    hdr_flow    = v.flow;
  endtask

  // Called at a negedge with hdr_ready high; returns at the negedge after the decision.
  task automatic send(input vec_t v, input string req);
    drive(v);
    hdr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hdr_valid = 1'b0;
    check({req, " ready low"}, 32'(hdr_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check({req, " R1 strobe"}, 32'(route_valid), 32'd1);
    check({req, " route"}, 32'(route), 32'(v.exp));
    check({req, " R1 flow"}, 32'(route_flow), 32'(v.flow));
  endtask

  task automatic do_reset(input string req, input bit poke);
    int n;
    bit seen;
    hdr_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({req, " reset strobe"}, 32'(route_valid), 32'd0);
    check({req, " reset ready"}, 32'(hdr_ready), 32'd0);
    rst_n = 1'b1;
    if (poke) begin
      drive('{1'b1, 1'b1, 1'b1, 32'd77, 16'd0, 8'd9, OU});
      hdr_valid = 1'b1;
    end
    n = 0;
    seen = 0;
    while (n < DEPTH + 10) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (route_valid) seen = 1;
      if (hdr_ready) break;
    end
    hdr_valid = 1'b0;
    check({req, " R11 sweep length"}, 32'(n), 32'(DEPTH + 2));
    check({req, " R11 no strobe in sweep"}, 32'(seen), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    hdr_valid = 1'b0;
    drive('0);
    do_reset("R11 first", 1'b1);
    // R11: the SYN poked during the sweep must not have armed flow 9
    send('{1'b1, 1'b1, 1'b0, 32'd5, 16'd1, 8'd9, BO}, "R11 poke ignored");
    send('{1'b1, 1'b1, 1'b0, 32'd77, 16'd1, 8'd9, DR}, "R11 poke ignored");

    for (int i = 0; i < NV; i++) send(VECS[i], $sformatf("vec %0d", i));

    // R10: header held through the busy cycle sees the previous update
    drive('{1'b1, 1'b1, 1'b1, 32'd10, 16'd0, 8'd5, OU});
    hdr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 busy", 32'(hdr_ready), 32'd0);
    drive('{1'b1, 1'b1, 1'b0, 32'd11, 16'd0, 8'd5, BO});
    @(posedge clk);
    @(negedge clk);
    check("R10 first decision", 32'(route), 32'(OU));
    check("R10 ready again", 32'(hdr_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    hdr_valid = 1'b0;
    check("R10 held header not taken early", 32'(route_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R10 held strobe", 32'(route_valid), 32'd1);
    check("R10 held sees update", 32'(route), 32'(BO));

    // R11: second reset wipes the active records (flow 1 expects 51)
    do_reset("R11 second", 1'b0);
    send('{1'b1, 1'b1, 1'b0, 32'd0, 16'd0, 8'd1, BO}, "R11 cleared record");
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule